// File: doc/BRIEF.md
# Nine-Bit Register Write Serializer

This block pushes register-write transactions to a display controller over a serial link that carries 9-bit words. Every transaction opens with a command word holding the register address. Up to two data words follow it. The top bit of each word tells the receiver whether the word is a command or data. The caller presents an address, a payload length and a 16-bit payload, and pulses a start strobe. The block then drives a chip select, a serial clock and a data line until the whole transaction has gone out.

The serial clock idles high. Data changes on the falling edge and the receiver samples it on the rising edge. The clock's half-period is a whole number of system clocks set by a compile-time parameter. After each transaction the chip select stays released for at least one full serial-clock period before another start can be taken. A one-cycle done pulse marks the moment the block becomes free again.

Top module: `n9_spi_writer`

## Requirements
- R1: Out of reset cs_no is 1, sclk_o is 1, busy_o is 0 and done_o is 0.
- R2: Every word is 9 bits sent MSB first. Bit 8 is 0 for the command word and 1 for a data word, and bits 7:0 carry the address or the data byte.
- R3: A transaction sends 1 + len_i words. A len_i value of 3 is treated as 2.
- R4: With len_i = 2 the first data word carries data_i[15:8] and the second carries data_i[7:0]. With len_i = 1 the single data word carries data_i[7:0].
- R5: mosi_o never changes in the cycle in which sclk_o rises.
- R6: While cs_no is high, sclk_o is high. All rising edges of sclk_o that carry data occur with cs_no low.
- R7: Each low phase of sclk_o lasts exactly HALF_DIV system clocks. HALF_DIV is at least 2.
- R8: A start_i pulse while busy_o is high is ignored and does not alter the transaction in flight.
- R9: done_o is a single-cycle pulse, given with cs_no high and busy_o low. cs_no stays high for at least 2*HALF_DIV clocks between transactions.
- R10: busy_o rises in the cycle after an accepted start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| addr_i | input | 8 | Register address for the command word |
| len_i | input | 2 | Number of data words (0..2, 3 treated as 2) |
| data_i | input | 16 | Payload, upper byte sent first when two words are sent |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when the block returns to idle |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a transaction. If the block wrongly took it, the damage would show only as a changed bit stream several words later. The stimulus waits until a two-data-word transaction is well under way, then pulses start_i with a different address and length. The scoreboard then checks that the words received and the word count still match the original request. A length value of 3 and back-to-back requests complete the coverage: the first tests the clamp to two data words, and the second tests the guard time at the edges of chip select.

// File: rtl/n9_spi_pkg.sv
package n9_spi_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GUARD
  } state_e;

  function automatic word_t cmd_word(input logic [BYTE_W-1:0] b);
    return {1'b0, b};
  endfunction

  function automatic word_t data_word(input logic [BYTE_W-1:0] b);
    return {1'b1, b};
  endfunction
endpackage

// File: rtl/n9_half_timer.sv
module n9_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/n9_word_shifter.sv
module n9_word_shifter
  import n9_spi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  word_t word_i,
  input  logic  shift_i,
  output logic  msb_o
);
  word_t sreg_q;

  assign msb_o = sreg_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sreg_q <= '0;
    else if (load_i)   sreg_q <= word_i;
    else if (shift_i)  sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end
endmodule

// File: rtl/n9_spi_writer.sv
module n9_spi_writer
  import n9_spi_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  addr_i,
  input  logic [1:0]  len_i,
  input  logic [15:0] data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  state_e        state_q;
  logic [15:0]   data_q;
  logic [1:0]    len_q, widx_q;
  logic [BW-1:0] bits_left_q;
  logic          guard_half_q, done_q;

  logic  tick, accept, last_bit, more_words, load, shift;
  word_t nxt_word, load_word;

  assign accept     = start_i && (state_q == ST_IDLE);
  assign last_bit   = (bits_left_q == '0);
  assign more_words = (widx_q < len_q);
  assign shift      = tick && (state_q == ST_HIGH) && !last_bit;
  assign load       = accept || (tick && (state_q == ST_HIGH) && last_bit && more_words);

  always_comb begin
    if (widx_q == 2'd0 && len_q == 2'd2) nxt_word = data_word(data_q[15:8]);
    else                                 nxt_word = data_word(data_q[7:0]);
    load_word = accept ? cmd_word(addr_i) : nxt_word;
  end

  n9_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  n9_word_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  (load_word),
    .shift_i (shift),
    .msb_o   (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      data_q       <= '0;
      len_q        <= '0;
      widx_q       <= '0;
      bits_left_q  <= '0;
      guard_half_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q     <= ST_LEAD;
          data_q      <= data_i;
          len_q       <= (len_i == 2'd3) ? 2'd2 : len_i;
          widx_q      <= '0;
          bits_left_q <= LAST_BIT;
        end
        ST_LEAD: if (tick) state_q <= ST_LOW;
        ST_LOW:  if (tick) state_q <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (!last_bit) begin
            bits_left_q <= bits_left_q - 1'b1;
            state_q     <= ST_LOW;
          end else if (more_words) begin
            widx_q      <= widx_q + 1'b1;
            bits_left_q <= LAST_BIT;
            state_q     <= ST_LOW;
          end else begin
            state_q     <= ST_TAIL;
          end
        end
        ST_TAIL: if (tick) begin
          state_q      <= ST_GUARD;
          guard_half_q <= 1'b0;
        end
        ST_GUARD: if (tick) begin
          if (guard_half_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            guard_half_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign sclk_o = (state_q != ST_LOW);
  assign cs_no  = (state_q == ST_IDLE) || (state_q == ST_GUARD);

  // R5
  mosi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  // R6
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o));
  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cs_no) |=> busy_o);
endmodule

// File: tb/n9_spi_writer_bench.sv
`timescale 1ns/1ps
module n9_spi_writer_bench;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  len_i = '0;
  logic [15:0] data_i = '0;
  logic        busy_o, done_o, sclk_o, mosi_o, cs_no;

  always #2 clk = ~clk;

  n9_spi_writer #(.HALF_DIV(HALF)) u_n9_spi_writer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .len_i(len_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no)
  );

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  int cnt_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] a, input logic [1:0] l, input logic [15:0] d);
    int n;
    n = (l == 2'd3) ? 2 : int'(l);
    exp_q.push_back({1'b0, a});
    if (n == 1) exp_q.push_back({1'b1, d[7:0]});
    if (n == 2) begin
      exp_q.push_back({1'b1, d[15:8]});
      exp_q.push_back({1'b1, d[7:0]});
    end
    cnt_q.push_back(n + 1);
  endtask

  task automatic send(input logic [7:0] a, input logic [1:0] l, input logic [15:0] d);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1; addr_i = a; len_i = l; data_i = d;
    push_exp(a, l, d);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
  endtask

  // start pulses while busy must not disturb the transfer
  task automatic poke_busy();
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b1, "R8 busy during poke", int'(busy_o), 1);
    start_i = 1'b1; addr_i = 8'h55; len_i = 2'd0; data_i = 16'hdead;
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    start_i = 1'b1; addr_i = 8'h66; len_i = 2'd1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // scoreboard monitor
  logic       prev_sclk = 1'b1, prev_cs = 1'b1, done_prev = 1'b0;
  logic [8:0] shreg = '0;
  int nbits = 0, words_seen = 0, low_run = 0, cs_high_run = 1000;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!cs_no && sclk_o && !prev_sclk) begin
        shreg = {shreg[7:0], mosi_o};
        nbits++;
        if (nbits == 9) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 extra word", int'(shreg), 0);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(shreg == e, "R2 R4 word", int'(shreg), int'(e));
          end
          words_seen++;
          nbits = 0;
        end
      end
      if (!sclk_o) low_run++;
      else if (!prev_sclk) begin
        chk(low_run == HALF, "R7 low phase", low_run, HALF);
        low_run = 0;
      end
      if (cs_no && !sclk_o) chk(1'b0, "R6 sclk low while deselected", 0, 1);
      if (cs_no) cs_high_run++;
      if (!cs_no && prev_cs) begin
        chk(cs_high_run >= 2*HALF, "R9 guard time", cs_high_run, 2*HALF);
        cs_high_run = 0;
      end
      if (done_o) begin
        chk(cs_no && !busy_o, "R9 done state", int'({cs_no, busy_o}), 2);
        chk(!done_prev, "R9 done width", int'(done_prev), 0);
        chk(nbits == 0, "R2 partial word", nbits, 0);
        if (cnt_q.size() == 0) chk(1'b0, "R3 unexpected done", words_seen, 0);
        else begin
          int n;
          n = cnt_q.pop_front();
          chk(words_seen == n, "R3 word count", words_seen, n);
        end
        words_seen = 0;
      end
      prev_sclk = sclk_o;
      prev_cs   = cs_no;
      done_prev = done_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1, "R1 cs", int'(cs_no), 1);
    chk(sclk_o == 1'b1, "R1 sclk", int'(sclk_o), 1);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy done", int'({busy_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1 && busy_o == 1'b0, "R1 idle after reset", int'({cs_no, busy_o}), 2);

    send(8'h10, 2'd0, 16'h0000);
    send(8'hb0, 2'd1, 16'hab17);
    send(8'hb8, 2'd2, 16'hfff9);
    send(8'ha5, 2'd3, 16'h1234);
    send(8'h3c, 2'd2, 16'h8001);
    poke_busy();
    send(8'hff, 2'd2, 16'h00ff);
    send(8'h00, 2'd1, 16'h5a80);

    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all words sent", exp_q.size(), 0);
    chk(cnt_q.size() == 0, "R3 all done pulses", cnt_q.size(), 0);
    chk(cs_no == 1'b1 && sclk_o == 1'b1, "R6 idle levels", int'({cs_no, sclk_o}), 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule